// File: doc/BRIEF.md
# Key-Guarded Nonvolatile Write Sequencer

This block sits on a simple register bus and decides when a nonvolatile memory write may begin. Software loads a target address, a source buffer address, an operation code and a write-enable bit. It then writes two fixed key words in a row and, as the very next access, sets the start bit through the set alias. Only that exact order launches the operation.

When the start is accepted, the block sends a one-cycle request to the memory array carrying the operation code and both addresses. It holds the start bit high until the array reports completion, and it records any error. After completion it refuses register writes for a short settling window. Each refused write is counted on an output so that the refusals can be observed.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset, the control register reads 0 (with `lowVolt` low), the target and source registers read 0, `flReq` is low and `dropCount` is 0.
- R2: Register offsets are: control 0x00, clear alias 0x04, set alias 0x08, key 0x10, target 0x20, source 0x40. A direct control write loads bit 14 (write enable), bit 13 (error) and bits 3:0 (operation code), and leaves bit 15 unchanged. The clear alias clears each of those bits written as 1, and the set alias sets each of them. The aliases and the key read as 0. Target and source read back what was written.
- R3: Writing 0xAA996655 and then 0x556699AA to the key register, followed directly by a set-alias write with bit 15 set, makes a start attempt.
- R4: A wrong key value, keys in the wrong order, or any read or write between the steps cancels the sequence. A set-alias write of bit 15 without the sequence is ignored: bit 15, bit 13 and `flReq` are unchanged.
- R5: A start attempt with write enable set and operation code 0001 (word), 0010 (quad word) or 0011 (row) sets bit 15 and raises `flReq` for exactly one cycle, in the cycle after the start write. During that cycle `flOp`, `flTarget` and `flSource` carry the register values.
- R6: A start attempt with write enable clear or with any other operation code sets bit 13, leaves bit 15 clear and issues no request.
- R7: Bit 15 stays set until `flDone` is sampled high and clears at that edge. If `flErr` is high with `flDone`, bit 13 is set.
- R8: While bit 15 is set, register writes have no effect.
- R9: For SETTLE_CYC (default 4) cycles after bit 15 clears, every write is dropped and `dropCount` increments once per dropped write. The next write after that window takes effect.
- R10: Control bit 11 reads the live level of `lowVolt`.
- R11: Each accepted or rejected start consumes the unlock, so a second set-alias start needs a fresh key pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (counts as an access) |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current `busAddr` |
| lowVolt | input | 1 | Low-voltage status, shown at control bit 11 |
| flReq | output | 1 | One-cycle operation request to the array |
| flOp | output | 4 | Operation code |
| flTarget | output | 32 | Target address |
| flSource | output | 32 | Source buffer address |
| flDone | input | 1 | Operation complete pulse |
| flErr | input | 1 | Error flag, sampled with `flDone` |
| dropCount | output | CNT_W | Number of writes dropped in settling windows |

## Verification
The assertions check the following on every cycle:
- the request is a single-cycle pulse that only follows a set-alias write of bit 15;
- the busy bit rises together with the request;
- the busy bit holds until completion and falls at the completion edge;
- the drop counter moves only on writes, and counts a write issued right after completion.

Only the bench scenarios can show the key ordering, that interrupted or wrong sequences are refused, that enable and operation-code faults are flagged, and that writes during busy or settling leave the register contents unchanged.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  localparam int REG_W = 32;
  localparam logic [31:0] KEY_FIRST  = 32'hAA99_6655;
  localparam logic [31:0] KEY_SECOND = 32'h5566_99AA;
  localparam int BIT_START = 15;
  localparam int BIT_EN    = 14;
  localparam int BIT_ERR   = 13;
  localparam int BIT_LV    = 11;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_CLR  = 8'h04;
  localparam logic [7:0] OFF_SET  = 8'h08;
  localparam logic [7:0] OFF_KEY  = 8'h10;
  localparam logic [7:0] OFF_TGT  = 8'h20;
  localparam logic [7:0] OFF_SRC  = 8'h40;
  localparam logic [3:0] OP_WORD = 4'b0001;
  localparam logic [3:0] OP_QUAD = 4'b0010;
  localparam logic [3:0] OP_ROW  = 4'b0011;

  typedef enum logic [1:0] {LK_IDLE, LK_FIRST, LK_ARMED} lock_t;

  typedef struct packed {
    logic ldCtrl;
    logic clrAlias;
    logic setAlias;
    logic ldTarget;
    logic ldSource;
    logic setErr;
  } fwg_strobe_t;

  function automatic logic opSupported(input logic [3:0] op);
    return (op == OP_WORD) || (op == OP_QUAD) || (op == OP_ROW);
  endfunction
endpackage

// File: rtl/fwg_ctrl.sv
module fwg_ctrl
  import fwg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              wrenQ,
  input  logic [3:0]        opQ,
  input  logic              flDone,
  input  logic              flErr,
  output logic              wrBit,
  output logic              flReq,
  output logic [CNT_W-1:0]  dropCount,
  output fwg_strobe_t       strobe
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SETTLE_LOAD = SET_W'(SETTLE_CYC);

  lock_t lockQ, lockD;
  logic [SET_W-1:0] settleQ;
  logic settling, blocked, wrAcc, anyAcc, keyHit1, keyHit2;
  logic startTry, startOk, finish;

  assign settling = (settleQ != '0);
  assign blocked  = wrBit | settling;
  assign anyAcc   = busWe | busRe;
  assign wrAcc    = busWe & ~blocked;
  assign keyHit1  = wrAcc && busAddr == ADDR_W'(OFF_KEY) && busWdata == KEY_FIRST;
  assign keyHit2  = wrAcc && busAddr == ADDR_W'(OFF_KEY) && busWdata == KEY_SECOND;
  assign startTry = wrAcc && busAddr == ADDR_W'(OFF_SET) && busWdata[BIT_START]
                    && lockQ == LK_ARMED;
  assign startOk  = startTry & wrenQ & opSupported(opQ);
  assign finish   = wrBit & flDone;

  always_comb begin
    lockD = lockQ;
    if (anyAcc) begin
      unique case (lockQ)
        LK_IDLE:  lockD = keyHit1 ? LK_FIRST : LK_IDLE;
        LK_FIRST: lockD = keyHit2 ? LK_ARMED : LK_IDLE;
        default:  lockD = LK_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.ldCtrl   = wrAcc && busAddr == ADDR_W'(OFF_CTRL);
    strobe.clrAlias = wrAcc && busAddr == ADDR_W'(OFF_CLR);
    strobe.setAlias = wrAcc && busAddr == ADDR_W'(OFF_SET);
    strobe.ldTarget = wrAcc && busAddr == ADDR_W'(OFF_TGT);
    strobe.ldSource = wrAcc && busAddr == ADDR_W'(OFF_SRC);
    strobe.setErr   = (startTry & ~startOk) | (finish & flErr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ     <= LK_IDLE;
      wrBit     <= 1'b0;
      flReq     <= 1'b0;
      settleQ   <= '0;
      dropCount <= '0;
    end else begin
      lockQ <= lockD;
      flReq <= startOk;
      if (startOk)     wrBit <= 1'b1;
      else if (finish) wrBit <= 1'b0;
      if (finish)        settleQ <= SETTLE_LOAD;
      else if (settling) settleQ <= settleQ - 1'b1;
      if (busWe && settling && !wrBit) dropCount <= dropCount + 1'b1;
    end
  end
endmodule

// File: rtl/fwg_dpath.sv
module fwg_dpath
  import fwg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fwg_strobe_t       strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              wrBit,
  input  logic              lowVolt,
  output logic [REG_W-1:0]  busRdata,
  output logic              wrenQ,
  output logic [3:0]        opQ,
  output logic [REG_W-1:0]  targetQ,
  output logic [REG_W-1:0]  sourceQ
);
  logic errQ, wrenD, errD;
  logic [3:0] opD;
  logic [REG_W-1:0] ctrlView;

  always_comb begin
    wrenD = wrenQ;
    errD  = errQ;
    opD   = opQ;
    if (strobe.ldCtrl) begin
      wrenD = busWdata[BIT_EN];
      errD  = busWdata[BIT_ERR];
      opD   = busWdata[3:0];
    end
    if (strobe.clrAlias) begin
      wrenD = wrenQ & ~busWdata[BIT_EN];
      errD  = errQ & ~busWdata[BIT_ERR];
      opD   = opQ & ~busWdata[3:0];
    end
    if (strobe.setAlias) begin
      wrenD = wrenQ | busWdata[BIT_EN];
      errD  = errQ | busWdata[BIT_ERR];
      opD   = opQ | busWdata[3:0];
    end
    if (strobe.setErr) errD = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrenQ   <= 1'b0;
      errQ    <= 1'b0;
      opQ     <= '0;
      targetQ <= '0;
      sourceQ <= '0;
    end else begin
      wrenQ <= wrenD;
      errQ  <= errD;
      opQ   <= opD;
      if (strobe.ldTarget) targetQ <= busWdata;
      if (strobe.ldSource) sourceQ <= busWdata;
    end
  end

  assign ctrlView = {16'h0, wrBit, wrenQ, errQ, 1'b0, lowVolt, 7'h0, opQ};

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFF_CTRL): busRdata = ctrlView;
      ADDR_W'(OFF_TGT):  busRdata = targetQ;
      ADDR_W'(OFF_SRC):  busRdata = sourceQ;
      default:           busRdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
  import fwg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              lowVolt,
  output logic              flReq,
  output logic [3:0]        flOp,
  output logic [31:0]       flTarget,
  output logic [31:0]       flSource,
  input  logic              flDone,
  input  logic              flErr,
  output logic [CNT_W-1:0]  dropCount
);
  fwg_strobe_t strobe;
  logic wrBit, wrenQ;
  logic [3:0] opQ;

  fwg_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .wrenQ(wrenQ), .opQ(opQ), .flDone(flDone), .flErr(flErr),
    .wrBit(wrBit), .flReq(flReq), .dropCount(dropCount), .strobe(strobe)
  );

  fwg_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr), .busWdata(busWdata),
    .wrBit(wrBit), .lowVolt(lowVolt), .busRdata(busRdata), .wrenQ(wrenQ), .opQ(opQ),
    .targetQ(flTarget), .sourceQ(flSource)
  );

  assign flOp = opQ;
endmodule

// File: rtl/fwg_chk.sv
module fwg_chk
  import fwg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              flReq,
  input logic              flDone,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wdataStart,
  input logic [CNT_W-1:0]  dropCount,
  input logic              wrBit
);
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    flReq |=> !flReq);

  p_req_with_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrBit) |-> flReq);

  p_req_after_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    flReq |-> ($past(busWe) && $past(busAddr) == ADDR_W'(OFF_SET) && $past(wdataStart)));

  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrBit && !flDone) |=> wrBit);

  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrBit && flDone) |=> !wrBit);

  p_settle_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wrBit) && busWe) |=> dropCount == CNT_W'($past(dropCount) + 1'b1));

  p_drop_needs_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> $past(busWe));
endmodule

bind flash_wr_guard fwg_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .flReq(flReq), .flDone(flDone), .busWe(busWe),
  .busAddr(busAddr), .wdataStart(busWdata[15]), .dropCount(dropCount), .wrBit(wrBit)
);

// File: tb/sim_flash_wr_guard.sv
`timescale 1ns/1ps
module sim_flash_wr_guard;
  localparam logic [31:0] K1 = 32'hAA99_6655;
  localparam logic [31:0] K2 = 32'h5566_99AA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0, lowVolt = 1'b0, flDone = 1'b0, flErr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, flTarget, flSource;
  logic [3:0] flOp;
  logic flReq;
  logic [7:0] dropCount;

  int checks = 0, fails = 0, reqCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flash_wr_guard u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .lowVolt(lowVolt), .flReq(flReq),
    .flOp(flOp), .flTarget(flTarget), .flSource(flSource), .flDone(flDone),
    .flErr(flErr), .dropCount(dropCount)
  );

  always @(negedge clk) if (flReq) reqCount++;

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_0000, 4'd1},  // R1 control reset
    '{1'b1, 8'h20, 32'h0000_0000, 4'd1},  // R1 target reset
    '{1'b0, 8'h20, 32'h1D00_0400, 4'd2},  // R2 target
    '{1'b1, 8'h20, 32'h1D00_0400, 4'd2},
    '{1'b0, 8'h40, 32'h0000_8000, 4'd2},  // R2 source
    '{1'b1, 8'h40, 32'h0000_8000, 4'd2},
    '{1'b0, 8'h00, 32'h0000_C003, 4'd2},  // R2 bit 15 not loadable
    '{1'b1, 8'h00, 32'h0000_4003, 4'd2},
    '{1'b0, 8'h04, 32'h0000_0001, 4'd2},  // R2 clear alias
    '{1'b1, 8'h00, 32'h0000_4002, 4'd2},
    '{1'b0, 8'h08, 32'h0000_0001, 4'd2},  // R2 set alias
    '{1'b1, 8'h00, 32'h0000_4003, 4'd2},
    '{1'b1, 8'h08, 32'h0000_0000, 4'd2},  // R2 alias reads 0
    '{1'b1, 8'h10, 32'h0000_0000, 4'd2},  // R2 key reads 0
    '{1'b0, 8'h08, 32'h0000_8000, 4'd4},  // R4 start without keys
    '{1'b1, 8'h00, 32'h0000_4003, 4'd4},
    '{1'b0, 8'h10, K1,            4'd4},  // R4 wrong second key
    '{1'b0, 8'h10, 32'h1234_5678, 4'd4},
    '{1'b0, 8'h10, K2,            4'd4},
    '{1'b0, 8'h08, 32'h0000_8000, 4'd4},
    '{1'b1, 8'h00, 32'h0000_4003, 4'd4},
    '{1'b0, 8'h10, K2,            4'd4},  // R4 reversed order
    '{1'b0, 8'h10, K1,            4'd4},
    '{1'b0, 8'h08, 32'h0000_8000, 4'd4},
    '{1'b1, 8'h00, 32'h0000_4003, 4'd4}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic unlockStart();
    wr(8'h10, K1);
    wr(8'h10, K2);
    wr(8'h08, 32'h0000_8000);
  endtask

  task automatic done(input logic e);
    flDone = 1'b1; flErr = e;
    @(negedge clk);
    flDone = 1'b0; flErr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    int rq;
    idle(3);
    check("R1 flReq", {31'h0, flReq}, 32'h0);
    check("R1 dropCount", {24'h0, dropCount}, 32'h0);
    rstN = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].a, r);
        check($sformatf("R%0d vec %0d", VEC[i].tag, i), r, VEC[i].d);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end
    check("R4 no request", reqCount, 0);

    // R3 / R5 accepted row start
    unlockStart();
    check("R5 flReq high", {31'h0, flReq}, 32'h1);
    check("R5 flOp", {28'h0, flOp}, 32'h3);
    check("R5 flTarget", flTarget, 32'h1D00_0400);
    check("R5 flSource", flSource, 32'h0000_8000);
    idle(1);
    check("R5 flReq single", {31'h0, flReq}, 32'h0);
    rd(8'h00, r);
    check("R7 busy set", r, 32'h0000_C003);
    // R8 write while busy ignored
    wr(8'h20, 32'hDEAD_0000);
    rd(8'h20, r);
    check("R8 busy write ignored", r, 32'h1D00_0400);
    idle(3);
    rd(8'h00, r);
    check("R7 busy held", r, 32'h0000_C003);
    // R9 settling window
    done(1'b0);
    wr(8'h20, 32'h0000_0011);
    wr(8'h20, 32'h0000_0022);
    wr(8'h20, 32'h0000_0033);
    wr(8'h20, 32'h0000_0044);
    wr(8'h20, 32'h0000_0055);
    rd(8'h20, r);
    check("R9 first write after window", r, 32'h0000_0055);
    check("R9 drop count", {24'h0, dropCount}, 32'h4);
    rd(8'h00, r);
    check("R7 busy cleared", r, 32'h0000_4003);
    check("R3 one request", reqCount, 1);

    // R11 unlock consumed
    wr(8'h08, 32'h0000_8000);
    rd(8'h00, r);
    check("R11 relock", r, 32'h0000_4003);

    // R6 write enable clear
    wr(8'h04, 32'h0000_4000);
    unlockStart();
    rd(8'h00, r);
    check("R6 no enable", r, 32'h0000_2003);
    wr(8'h04, 32'h0000_2000);
    wr(8'h00, 32'h0000_4005);
    unlockStart();
    rd(8'h00, r);
    check("R6 bad opcode", r, 32'h0000_6005);
    check("R6 no request", reqCount, 1);

    // R7 error from array, word op
    wr(8'h00, 32'h0000_4001);
    rq = reqCount;
    unlockStart();
    check("R5 word op", {28'h0, flOp}, 32'h1);
    idle(2);
    check("R5 word request", reqCount, rq + 1);
    done(1'b1);
    idle(6);
    rd(8'h00, r);
    check("R7 array error", r, 32'h0000_6001);

    // R10 low-voltage mirror
    lowVolt = 1'b1;
    rd(8'h00, r);
    check("R10 lowVolt", r, 32'h0000_6801);
    lowVolt = 1'b0;

    // R1 mid-run reset
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    rd(8'h00, r);
    check("R1 ctrl after reset", r, 32'h0);
    rd(8'h40, r);
    check("R1 source after reset", r, 32'h0);
    check("R1 drop after reset", {24'h0, dropCount}, 32'h0);

    finished = 1;
    report();
  end
endmodule